// File: doc/BRIEF.md
# Triple-Stored Configuration Register Bank with Fuse Boot

This block keeps the static configuration of a chip in a bank of byte-wide registers. Each register is held in three copies, and the value the chip sees is the bitwise majority of the three. On every clock, any copy that no longer matches the majority is rewritten with it. A flipped bit therefore lasts at most one cycle, and upsets that hit different copies in later cycles are never combined.

The bank gets its contents from one of two sources, and a single fuse flag chooses between them. The flag is sampled on the first clock edge after reset. When it is set, a sequencer walks the non-volatile fuse memory from address 0 upward and copies one byte per clock. The fuse memory is modelled as an asynchronous read port. When the flag is clear, the registers start at zero and software loads them through a byte-addressed write port.

The write port uses valid/ready. A write is taken on an edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays low until the bank is ready, so the writer must hold its request until then. Reads are a request/response pair with no back-pressure: `rd_ack` follows one cycle after `rd_valid`, together with the voted byte. A fault-injection port can invert bits in a chosen copy so the voting and scrubbing can be exercised.

Top module: `cfg_bank_tmr`

## Requirements
- R1: The bank holds NUM_REGS (300) registers of 8 bits each. After reset with the fuse source off, every register reads 0x00.
- R2: `fuse_use` is sampled on the first rising edge after reset is released, and `src_fuse` then shows the sampled value. Later changes of `fuse_use` have no effect until the next reset.
- R3: With the fuse source on, one fuse byte is copied per clock, in ascending order from address 0 to 299. After the k-th edge following reset release (1 ≤ k ≤ 300), `fuse_addr` equals k−1. `load_done` rises after edge 301, and is still low after edge 300.
- R4: When the fuse copy has finished, every register holds the byte the fuse memory returned for its address.
- R5: `wr_ready` is low until `load_done` is high. A write offered while `wr_ready` is low is not taken and leaves the register unchanged.
- R6: A write taken to an address below 300 makes that register, and its slice of `cfg_q` (bits addr*8+7 down to addr*8), hold the data after the same edge.
- R7: A write to an address of 300 or more is taken but changes no register. A read of such an address returns 0x00.
- R8: One cycle after `rd_valid`, `rd_ack` is high and `rd_data` carries the voted value of `rd_addr`.
- R9: An upset of one copy (`upset_copy` 0, 1 or 2, bits given by `upset_mask`) never changes the voted output.
- R10: A copy that disagrees with the vote is rewritten on the next edge. As a result, upsets to two different copies on consecutive cycles leave the voted value intact.
- R11: With the fuse source off, `load_done` is high after the first edge following reset release. In both modes it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fuse_use | input | 1 | Fuse flag selecting the fuse bank as configuration source |
| fuse_addr | output | 9 | Fuse memory read address |
| fuse_data | input | 8 | Fuse memory read data, valid in the same cycle |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Bank can accept a write |
| wr_addr | input | 9 | Write address |
| wr_data | input | 8 | Write data |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 9 | Read address |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | 8 | Voted read data |
| upset_valid | input | 1 | Fault-injection strobe |
| upset_addr | input | 9 | Register hit by the upset |
| upset_copy | input | 2 | Copy hit (0 to 2; 3 hits none) |
| upset_mask | input | 8 | Bits to invert in that copy |
| load_done | output | 1 | Configuration source finished, bank usable |
| src_fuse | output | 1 | Sampled source: 1 fuses, 0 write port |
| cfg_q | output | 2400 | All voted registers, register n in bits n*8+7 down to n*8 |

## Verification
The fuse copy is run against a fuse model whose byte depends on its address. A shifted, skipped or repeated address therefore shows up as a wrong value, and sampling `fuse_addr` and `load_done` at fixed edges separates a correct sequencer from one that is off by one. Port writes walk a vector table that covers the first, last and middle addresses, all-ones, all-zeros and single-bit data, and an overwrite. Each write is checked on `cfg_q` and again through a read. Out-of-range and back-pressured writes are followed by a full comparison of the bank, which catches an aliased write anywhere. Upsets hit a single copy, and then two copies on consecutive cycles; only the second pattern can tell a scrubbing bank from one that only votes.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef enum logic [1:0] {
    LD_START = 2'd0,
    LD_COPY  = 2'd1,
    LD_DONE  = 2'd2
  } ld_state_e;

  localparam int COPIES = 3;
endpackage

// File: rtl/tmr_byte_cell.sv
module tmr_byte_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         flip_en,
  input  logic [1:0]   flip_copy,
  input  logic [W-1:0] flip_mask,
  output logic [W-1:0] q
);
  import cfg_bank_pkg::*;

  logic [W-1:0] copy_q [COPIES];

  // bitwise majority of the three copies
  assign q = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk) begin
      if (!rst_n)
        copy_q[c] <= '0;
      else if (wr_en)
        copy_q[c] <= wr_data;
      else if (flip_en && flip_copy == 2'(c))
        copy_q[c] <= copy_q[c] ^ flip_mask;
      else
        copy_q[c] <= q;   // scrub toward the vote
    end
  end

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data));

  // R9
  single_upset_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_en && !wr_en) |=> $stable(q));

  // R10
  scrub_converge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip_en && !wr_en) |=> (copy_q[0] == copy_q[1] && copy_q[1] == copy_q[2]));
endmodule

// File: rtl/cfg_fuse_loader.sv
module cfg_fuse_loader #(
  parameter int N  = 300,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fuse_use,
  output logic [AW-1:0] fuse_addr,
  output logic          load_we,
  output logic          load_done,
  output logic          src_fuse
);
  import cfg_bank_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  ld_state_e     st;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LD_START;
      cnt      <= '0;
      src_fuse <= 1'b0;
    end else begin
      case (st)
        LD_START: begin
          src_fuse <= fuse_use;
          cnt      <= '0;
          st       <= fuse_use ? LD_COPY : LD_DONE;
        end
        LD_COPY: begin
          if (cnt == LAST) st <= LD_DONE;
          else             cnt <= cnt + 1'b1;
        end
        default: st <= LD_DONE;
      endcase
    end
  end

  assign fuse_addr = cnt;
  assign load_we   = (st == LD_COPY);
  assign load_done = (st == LD_DONE);

  // R3
  fuse_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LD_COPY && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);

  // R3
  fuse_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LD_COPY) |-> cnt <= LAST);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  // R2
  src_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != LD_START) |=> $stable(src_fuse));
endmodule

// File: rtl/cfg_bank_tmr.sv
module cfg_bank_tmr #(
  parameter int NUM_REGS = 300,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fuse_use,
  output logic [ADDR_W-1:0]          fuse_addr,
  input  logic [DATA_W-1:0]          fuse_data,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_valid,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic                       rd_ack,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       upset_valid,
  input  logic [ADDR_W-1:0]          upset_addr,
  input  logic [1:0]                 upset_copy,
  input  logic [DATA_W-1:0]          upset_mask,
  output logic                       load_done,
  output logic                       src_fuse,
  output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_REGS - 1);

  logic              load_we;
  logic              wr_take;
  logic [DATA_W-1:0] cell_wdata;
  logic [DATA_W-1:0] vote_arr [NUM_REGS];

  cfg_fuse_loader #(.N(NUM_REGS), .AW(ADDR_W)) loader_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fuse_use  (fuse_use),
    .fuse_addr (fuse_addr),
    .load_we   (load_we),
    .load_done (load_done),
    .src_fuse  (src_fuse)
  );

  assign wr_ready   = load_done;
  assign wr_take    = wr_valid && wr_ready;
  assign cell_wdata = load_we ? fuse_data : wr_data;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic cell_we;
    assign cell_we = load_we ? (fuse_addr == ADDR_W'(i))
                             : (wr_take && wr_addr == ADDR_W'(i));

    tmr_byte_cell #(.W(DATA_W)) cell_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cell_we),
      .wr_data   (cell_wdata),
      .flip_en   (upset_valid && upset_addr == ADDR_W'(i)),
      .flip_copy (upset_copy),
      .flip_mask (upset_mask),
      .q         (vote_arr[i])
    );

    assign cfg_q[i*DATA_W +: DATA_W] = vote_arr[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= rd_valid;
      if (rd_valid)
        rd_data <= (rd_addr <= TOP_ADDR) ? vote_arr[rd_addr] : '0;
    end
  end

  // R8
  rd_ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_ack);

  // R7
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr > TOP_ADDR) |=> rd_data == '0);

  // R5
  no_write_while_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |-> !wr_ready);
endmodule

// File: tb/cfg_bank_tmr_tb_top.sv
`timescale 1ns/1ps
module cfg_bank_tmr_tb_top;
  localparam int N = 300;
  localparam int W = 8;
  localparam int AW = 9;

  // write vectors {addr, data}, each written then read back
  localparam logic [16:0] VEC [8] = '{
    {9'd0,   8'h5A}, {9'd1,   8'hA5}, {9'd299, 8'hFF}, {9'd150, 8'h01},
    {9'd77,  8'h80}, {9'd298, 8'h3C}, {9'd1,   8'h00}, {9'd200, 8'hC3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fuse_use = 1'b0;
  logic [AW-1:0] fuse_addr;
  logic [W-1:0]  fuse_data;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_ack;
  logic [W-1:0]  rd_data;
  logic          upset_valid = 1'b0;
  logic [AW-1:0] upset_addr = '0;
  logic [1:0]    upset_copy = '0;
  logic [W-1:0]  upset_mask = '0;
  logic          load_done;
  logic          src_fuse;
  logic [N*W-1:0] cfg_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [W-1:0] model [N];

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] fuse_val(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  assign fuse_data = fuse_val(int'(fuse_addr));

  cfg_bank_tmr dut_i (
    .clk(clk), .rst_n(rst_n), .fuse_use(fuse_use), .fuse_addr(fuse_addr),
    .fuse_data(fuse_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .upset_valid(upset_valid),
    .upset_addr(upset_addr), .upset_copy(upset_copy), .upset_mask(upset_mask),
    .load_done(load_done), .src_fuse(src_fuse), .cfg_q(cfg_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit src);
    @(negedge clk);
    rst_n = 1'b0;
    fuse_use = src;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [W-1:0] d, output logic ack);
    rd_valid = 1'b1; rd_addr = a;
    tick();
    rd_valid = 1'b0;
    d = rd_data; ack = rd_ack;
  endtask

  task automatic do_upset(input logic [AW-1:0] a, input logic [1:0] c, input logic [W-1:0] m);
    upset_valid = 1'b1; upset_addr = a; upset_copy = c; upset_mask = m;
    tick();
    upset_valid = 1'b0;
  endtask

  function automatic int bank_mismatches();
    int n = 0;
    for (int i = 0; i < N; i++)
      if (cfg_q[i*W +: W] !== model[i]) n++;
    return n;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic ack;

    // ---------- fuse source ----------
    do_reset(1'b1);
    chk(load_done == 1'b0, "R3 done low in reset", 32'(load_done), 32'd0);
    for (int e = 1; e <= 301; e++) begin
      tick();
      if (e == 1) begin
        chk(src_fuse == 1'b1, "R2 src_fuse after sample", 32'(src_fuse), 32'd1);
        chk(fuse_addr == 9'd0, "R3 first fuse addr", 32'(fuse_addr), 32'd0);
      end
      if (e == 10) begin
        wr_valid = 1'b1; wr_addr = 9'd5; wr_data = 8'hAA;
      end
      if (e == 11) begin
        chk(wr_ready == 1'b0, "R5 ready low while copying", 32'(wr_ready), 32'd0);
        wr_valid = 1'b0;
      end
      if (e == 150)
        chk(fuse_addr == 9'd149, "R3 fuse addr mid copy", 32'(fuse_addr), 32'd149);
      if (e == 300)
        chk(load_done == 1'b0, "R3 done low at edge 300", 32'(load_done), 32'd0);
      if (e == 301)
        chk(load_done == 1'b1, "R3 done at edge 301", 32'(load_done), 32'd1);
    end
    for (int i = 0; i < N; i++) model[i] = fuse_val(i);
    chk(bank_mismatches() == 0, "R4 whole bank from fuses", 32'(bank_mismatches()), 32'd0);
    do_read(9'd5, d, ack);
    chk(d == fuse_val(5), "R5 write during copy not taken", 32'(d), 32'(fuse_val(5)));
    do_read(9'd299, d, ack);
    chk(d == fuse_val(299) && ack, "R8 read last fuse byte", 32'(d), 32'(fuse_val(299)));
    fuse_use = 1'b0;
    repeat (3) tick();
    chk(src_fuse == 1'b1, "R2 late flag change ignored", 32'(src_fuse), 32'd1);
    chk(load_done == 1'b1 && wr_ready == 1'b1, "R11 done sticky", 32'(load_done), 32'd1);

    // ---------- write-port source ----------
    do_reset(1'b0);
    tick();
    chk(load_done == 1'b1, "R11 done after one edge", 32'(load_done), 32'd1);
    chk(src_fuse == 1'b0, "R2 src_fuse clear", 32'(src_fuse), 32'd0);
    for (int i = 0; i < N; i++) model[i] = '0;
    chk(bank_mismatches() == 0, "R1 bank zero after reset", 32'(bank_mismatches()), 32'd0);

    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  x;
      a = VEC[v][16:8];
      x = VEC[v][7:0];
      do_write(a, x);
      model[a] = x;
      chk(cfg_q[a*W +: W] == x, "R6 cfg_q after write", 32'(cfg_q[a*W +: W]), 32'(x));
      do_read(a, d, ack);
      chk(d == x && ack == 1'b1, "R8 read back", 32'(d), 32'(x));
    end

    // out of range
    do_write(9'd300, 8'h77);
    do_write(9'd511, 8'hEE);
    chk(bank_mismatches() == 0, "R7 oob write changes nothing", 32'(bank_mismatches()), 32'd0);
    do_read(9'd300, d, ack);
    chk(d == 8'h00 && ack == 1'b1, "R7 oob read 300", 32'(d), 32'd0);
    do_read(9'd511, d, ack);
    chk(d == 8'h00, "R7 oob read 511", 32'(d), 32'd0);

    // single upset
    do_upset(9'd77, 2'd0, 8'hFF);
    chk(cfg_q[77*W +: W] == 8'h80, "R9 single upset masked", 32'(cfg_q[77*W +: W]), 32'h80);
    do_upset(9'd200, 2'd2, 8'h0F);
    do_read(9'd200, d, ack);
    chk(d == 8'hC3, "R9 upset copy 2 masked on read", 32'(d), 32'hC3);

    // consecutive upsets on different copies
    upset_valid = 1'b1; upset_addr = 9'd150; upset_copy = 2'd0; upset_mask = 8'h01;
    tick();
    upset_copy = 2'd1;
    tick();
    upset_valid = 1'b0;
    chk(cfg_q[150*W +: W] == 8'h01, "R10 scrub between upsets", 32'(cfg_q[150*W +: W]), 32'h01);
    upset_valid = 1'b1; upset_addr = 9'd298; upset_copy = 2'd2; upset_mask = 8'hC3;
    tick();
    upset_copy = 2'd0;
    tick();
    upset_valid = 1'b0;
    tick();
    do_read(9'd298, d, ack);
    chk(d == 8'h3C, "R10 scrub copies 2 then 0", 32'(d), 32'h3C);
    chk(bank_mismatches() == 0, "R10 bank intact after upsets", 32'(bank_mismatches()), 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule